// File: doc/BRIEF.md
# Dual-Rate Serial Baud Bridge

This block joins two asynchronous serial links that run at very different rates. On one side is a fast host link at 115200 baud, and on the other is a slow legacy UART at 9600 baud. Each direction has its own receiver, byte queue and transmitter.

Host bytes are queued and sent on to the legacy line at the slow rate. Legacy bytes are queued and sent on to the host at the fast rate. Both bit-period dividers come from a single system clock of about 6.25 MHz.

The fast host can deliver bytes much faster than the slow side can drain them. A DTR output therefore tells the host when to pause, so that its average inbound rate stays close to the slow link's rate.

Inside the block, each receiver pushes into its queue with a valid strobe and cannot be stalled. Each transmitter pulls from its queue with a valid/ready handshake: it asserts ready only while its line is idle. A byte that meets a full queue is lost, and this is recorded in a sticky flag. The only back-pressure toward the host is DTR.

Top module: `serial_rate_bridge`

## Requirements
- R1: After reset, `host_txd` and `legacy_txd` rest high, `host_dtr` is high, and both overflow flags are low.
- R2: Every frame on all four lines is 8N1. A frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. A received frame whose stop bit samples low is discarded.
- R3: With default parameters, one bit lasts 54 clock cycles on `host_rxd` and `host_txd`. It lasts 651 clock cycles on `legacy_rxd` and `legacy_txd`.
- R4: Bytes received on `host_rxd` are sent on `legacy_txd` in arrival order, unless they are dropped under R7.
- R5: Bytes received on `legacy_rxd` are sent on `host_txd` in arrival order.
- R6: Let N be the number of bytes waiting in the host-to-legacy queue. DTR is high when the host may send and low when it must pause.
  - `host_dtr` goes low one cycle after N reaches 4 or more.
  - It goes high one cycle after N falls to 1 or fewer.
  - While N is 2 or 3, it keeps its previous value.
- R7: Each queue holds 8 bytes, and the transmitter holds one more byte while sending it. A byte that arrives while its queue is full is dropped, and the bytes already queued are sent unchanged.
- R8: `h2l_overflow` (host-to-legacy direction) and `l2h_overflow` (legacy-to-host direction) each go high when a byte is dropped in their direction. Each stays high until reset.
- R9: A receiver confirms a start bit at mid-bit and samples each data bit at mid-bit. A low pulse shorter than half a bit on an idle line yields no byte.
- R10: The two directions work at the same time without interfering with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about 6.25 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rxd | input | 1 | Serial data from the host, fast rate |
| host_txd | output | 1 | Serial data to the host, fast rate |
| host_dtr | output | 1 | High: host may send; low: host must pause |
| legacy_rxd | input | 1 | Serial data from the legacy UART, slow rate |
| legacy_txd | output | 1 | Serial data to the legacy UART, slow rate |
| h2l_overflow | output | 1 | Sticky: a host byte was dropped |
| l2h_overflow | output | 1 | Sticky: a legacy byte was dropped |

## Verification
The bench fires a burst of twelve host bytes while ignoring DTR. Exactly the first nine must come out on the legacy line, and the overflow flag must rise. A design with an off-by-one queue depth would emit eight or ten bytes, and one that overwrites a full queue would emit the last bytes in place of the earlier ones.

The bench also measures how long DTR stays low. That span is three slow-byte drain periods, shortened by the host bytes already delivered. A design without hysteresis would raise DTR after only one drain period.

A 100-cycle glitch on the idle legacy line must produce no byte, which catches a receiver that does not confirm the start bit at mid-bit. Traffic runs in both directions at once, so any cross-coupling between the lanes shows up as corrupted or reordered bytes.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef logic [7:0] byte_t;

  // Clock cycles per bit, rounded to the nearest integer.
  function automatic int div_round(input int clk_hz, input int baud);
    return (clk_hz + baud / 2) / baud;
  endfunction
endpackage

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int DIV = 54
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  output logic               out_valid,
  output bridge_pkg::byte_t  out_data
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bitn;
  logic [1:0]        sync;
  bridge_pkg::byte_t shreg;
  logic              line;

  assign line = sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync      <= 2'b11;
      state     <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sync      <= {sync[0], rxd};
      out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (!line) state <= S_START;
        end
        S_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            state <= line ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt == CW'(DIV - 1)) begin
            cnt   <= '0;
            shreg <= {line, shreg[7:1]};
            if (bitn == 3'd7) state <= S_STOP;
            bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt == CW'(DIV - 1)) begin
            cnt   <= '0;
            state <= S_IDLE;
            if (line) begin
              out_valid <= 1'b1;
              out_data  <= shreg;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DIV = 54
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  bridge_pkg::byte_t  in_data,
  output logic               txd
);
  localparam int CW = $clog2(DIV);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [9:0]    frame;

  assign in_ready = !busy;
  assign txd      = frame[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      frame <= '1;
    end else if (!busy) begin
      if (in_valid) begin
        busy  <= 1'b1;
        cnt   <= '0;
        bitn  <= '0;
        frame <= {1'b1, in_data, 1'b0};
      end
    end else if (cnt == CW'(DIV - 1)) begin
      cnt   <= '0;
      frame <= {1'b1, frame[9:1]};
      bitn  <= bitn + 1'b1;
      if (bitn == 4'd9) busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  bridge_pkg::byte_t  wr_data,
  input  logic               rd_ready,
  output bridge_pkg::byte_t  rd_data,
  output logic [LW-1:0]      level,
  output logic               dropped
);
  bridge_pkg::byte_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic full, push, pop;

  assign full    = (level == LW'(DEPTH));
  assign push    = wr_valid && !full;
  assign pop     = rd_ready && (level != '0);
  assign rd_data = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      dropped <= 1'b0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_valid && full) dropped <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_rate_bridge.sv
module serial_rate_bridge #(
  parameter int CLK_HZ        = 6_250_000,
  parameter int HOST_BAUD     = 115_200,
  parameter int LEGACY_BAUD   = 9_600,
  parameter int FIFO_DEPTH    = 8,
  parameter int DTR_OFF_LEVEL = 4,
  parameter int DTR_ON_LEVEL  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_rxd,
  output logic host_txd,
  output logic host_dtr,
  input  logic legacy_rxd,
  output logic legacy_txd,
  output logic h2l_overflow,
  output logic l2h_overflow
);
  import bridge_pkg::*;

  localparam int HOST_DIV   = div_round(CLK_HZ, HOST_BAUD);
  localparam int LEGACY_DIV = div_round(CLK_HZ, LEGACY_BAUD);
  localparam int LW         = $clog2(FIFO_DEPTH + 1);

  // host -> legacy lane
  logic          h2l_rx_valid, h2l_tx_ready;
  byte_t         h2l_rx_data, h2l_head;
  logic [LW-1:0] h2l_level;

  uart_rx #(.DIV(HOST_DIV)) u_host_rx (
    .clk(clk), .rst_n(rst_n), .rxd(host_rxd),
    .out_valid(h2l_rx_valid), .out_data(h2l_rx_data));

  byte_fifo #(.DEPTH(FIFO_DEPTH)) u_h2l_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(h2l_rx_valid), .wr_data(h2l_rx_data),
    .rd_ready(h2l_tx_ready), .rd_data(h2l_head), .level(h2l_level),
    .dropped(h2l_overflow));

  uart_tx #(.DIV(LEGACY_DIV)) u_legacy_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(h2l_level != '0),
    .in_ready(h2l_tx_ready), .in_data(h2l_head), .txd(legacy_txd));

  // legacy -> host lane
  logic          l2h_rx_valid, l2h_tx_ready;
  byte_t         l2h_rx_data, l2h_head;
  logic [LW-1:0] l2h_level;

  uart_rx #(.DIV(LEGACY_DIV)) u_legacy_rx (
    .clk(clk), .rst_n(rst_n), .rxd(legacy_rxd),
    .out_valid(l2h_rx_valid), .out_data(l2h_rx_data));

  byte_fifo #(.DEPTH(FIFO_DEPTH)) u_l2h_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(l2h_rx_valid), .wr_data(l2h_rx_data),
    .rd_ready(l2h_tx_ready), .rd_data(l2h_head), .level(l2h_level),
    .dropped(l2h_overflow));

  uart_tx #(.DIV(HOST_DIV)) u_host_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(l2h_level != '0),
    .in_ready(l2h_tx_ready), .in_data(l2h_head), .txd(host_txd));

  // DTR with hysteresis on host->legacy occupancy
  always_ff @(posedge clk) begin
    if (!rst_n)                            host_dtr <= 1'b1;
    else if (h2l_level >= LW'(DTR_OFF_LEVEL)) host_dtr <= 1'b0;
    else if (h2l_level <= LW'(DTR_ON_LEVEL))  host_dtr <= 1'b1;
  end
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int DEPTH = 8,
  parameter int OFF_LEVEL = 4,
  parameter int ON_LEVEL = 1,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_dtr,
  input logic [LW-1:0] h2l_level,
  input logic          h2l_overflow,
  input logic          l2h_overflow
);
  // R6
  dtr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_dtr) |-> ($past(h2l_level) >= LW'(OFF_LEVEL)));
  // R6
  dtr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_dtr) |-> ($past(h2l_level) <= LW'(ON_LEVEL)));
  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2l_level <= LW'(DEPTH));
  // R7
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((h2l_level == $past(h2l_level)) || (h2l_level == $past(h2l_level) + 1'b1)
              || (h2l_level + 1'b1 == $past(h2l_level))));
  // R8
  h2l_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2l_overflow |=> h2l_overflow);
  // R8
  l2h_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2h_overflow |=> l2h_overflow);
endmodule

bind serial_rate_bridge bridge_checker #(
  .DEPTH(FIFO_DEPTH), .OFF_LEVEL(DTR_OFF_LEVEL), .ON_LEVEL(DTR_ON_LEVEL), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_dtr(host_dtr), .h2l_level(h2l_level),
  .h2l_overflow(h2l_overflow), .l2h_overflow(l2h_overflow));

// File: tb/serial_rate_bridge_test.sv
`timescale 1ns/1ps
module serial_rate_bridge_test;
  localparam int FAST = 54;
  localparam int SLOW = 651;
  localparam int KEEP = 9;
  localparam int LIMIT = 190_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rxd = 1'b1, legacy_rxd = 1'b1;
  logic host_txd, host_dtr, legacy_txd, h2l_overflow, l2h_overflow;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] exp_leg[$], exp_host[$], got_leg[$], got_host[$];

  always #2.5 clk = ~clk;

  serial_rate_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_rxd(host_rxd), .host_txd(host_txd),
    .host_dtr(host_dtr), .legacy_rxd(legacy_rxd), .legacy_txd(legacy_txd),
    .h2l_overflow(h2l_overflow), .l2h_overflow(l2h_overflow));

  function automatic logic kept(input int idx);
    return idx < KEEP;
  endfunction

  function automatic int dtr_low_span();
    return 3 * (10 * SLOW + 1) - 4 * (10 * FAST) - FAST / 2;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic host_side, input logic [7:0] b);
    int d = host_side ? FAST : SLOW;
    logic [9:0] fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (host_side) host_rxd = fr[i]; else legacy_rxd = fr[i];
      repeat (d - 1) @(negedge clk);
    end
  endtask

  task automatic monitor(input logic host_side);
    int d = host_side ? FAST : SLOW;
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if ((host_side ? host_txd : legacy_txd) == 1'b0) begin
        repeat (d / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (d) @(negedge clk);
          b[i] = host_side ? host_txd : legacy_txd;
        end
        repeat (d) @(negedge clk);
        // R2: stop bit high at the R3 bit period
        check((host_side ? host_txd : legacy_txd) == 1'b1, "R2/R3 stop bit",
              host_side ? host_txd : legacy_txd, 1);
        if (host_side) got_host.push_back(b); else got_leg.push_back(b);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] b;
    int t_fall, span, n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(host_txd == 1'b1, "R1 host_txd idle", host_txd, 1);
    check(legacy_txd == 1'b1, "R1 legacy_txd idle", legacy_txd, 1);
    check(host_dtr == 1'b1, "R1 dtr", host_dtr, 1);
    check(h2l_overflow == 1'b0, "R1 h2l_overflow", h2l_overflow, 0);
    check(l2h_overflow == 1'b0, "R1 l2h_overflow", l2h_overflow, 0);
    fork
      monitor(1'b1);
      monitor(1'b0);
    join_none

    // R10: both directions concurrently
    fork
      begin // R5
        for (int k = 0; k < 3; k++) begin
          b = 8'($urandom);
          exp_host.push_back(b);
          send(1'b0, b);
        end
      end
      begin // R4 / R6
        for (int k = 0; k < 6; k++) begin
          logic [7:0] hb = 8'($urandom);
          if (k == 5) begin
            check(host_dtr == 1'b0, "R6 dtr low at 4 queued", host_dtr, 0);
            t_fall = cyc;
            while (!host_dtr) @(negedge clk);
            span = cyc - t_fall;
            check(span > dtr_low_span() - 100 && span < dtr_low_span() + 100,
                  "R6 dtr low span", span, dtr_low_span());
          end
          exp_leg.push_back(hb);
          send(1'b1, hb);
        end
      end
    join
    while (got_leg.size() < 6 && cyc < LIMIT) @(negedge clk);
    repeat (700) @(negedge clk);
    check(h2l_overflow == 1'b0, "R8 no overflow with DTR obeyed", h2l_overflow, 0);

    // R7: burst of 12 ignoring DTR
    for (int k = 0; k < 12; k++) begin
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'($urandom);
      if (kept(k)) exp_leg.push_back(b);
      send(1'b1, b);
    end
    check(h2l_overflow == 1'b1, "R8 overflow set", h2l_overflow, 1);
    while (got_leg.size() < 6 + KEEP && cyc < LIMIT) @(negedge clk);
    repeat (8000) @(negedge clk);
    check(got_leg.size() == 6 + KEEP, "R7 bytes kept", got_leg.size(), 6 + KEEP);
    check(h2l_overflow == 1'b1, "R8 overflow sticky", h2l_overflow, 1);
    check(host_dtr == 1'b1, "R6 dtr back high when drained", host_dtr, 1);
    check(l2h_overflow == 1'b0, "R8 l2h no overflow", l2h_overflow, 0);

    // R9: short glitch on idle legacy line
    @(negedge clk) legacy_rxd = 1'b0;
    repeat (100) @(negedge clk);
    legacy_rxd = 1'b1;
    repeat (3000) @(negedge clk);
    check(got_host.size() == 3, "R9 glitch ignored", got_host.size(), 3);

    n = (got_leg.size() < exp_leg.size()) ? got_leg.size() : exp_leg.size();
    for (int i = 0; i < n; i++)
      check(got_leg[i] == exp_leg[i], "R4/R7 legacy byte order", got_leg[i], exp_leg[i]);
    n = (got_host.size() < exp_host.size()) ? got_host.size() : exp_host.size();
    check(got_host.size() == exp_host.size(), "R5 host byte count", got_host.size(), exp_host.size());
    for (int i = 0; i < n; i++)
      check(got_host[i] == exp_host[i], "R5 host byte order", got_host[i], exp_host[i]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule